// File: doc/BRIEF.md
# Two-Channel Fetch-and-Store DMA Mover

The block moves data on behalf of two peripherals without processor help. Each channel holds a source pointer, a destination pointer, a transfer counter and a control word. Software sets these through a small register port. An external request line, one per channel, is active high and level sensitive. While it is held high, the channel repeats transfers. Each transfer reads a byte or a word from the source into an internal holding register and then writes it to the destination. Each side may sit in memory space or in I/O space. After each transfer each pointer moves up, moves down or stays where it is.

The master side is a request/acknowledge port that works like a valid/ready stream. The block raises `bus_req` together with the address, space, size, direction and write data. It holds all of them unchanged until the cycle in which `bus_ack` is high, and that cycle completes the bus cycle. A slow target applies back-pressure by holding `bus_ack` low for as long as it needs. Read data is taken in the acknowledge cycle. Byte data always travels on the low eight bits of the data buses. Word data is little-endian: the byte at the even address is on bits 7:0.

Registers are selected by `cfg_sel = {channel, index}`: index 0 is the source pointer, 1 the destination pointer, 2 the counter and 3 the control word. Control bits: 0 run, 1 word size, 3:2 source step, 5:4 destination step, 6 source in I/O space, 7 destination in I/O space, 8 stop at terminal count, 9 interrupt enable.

Top module: `dma2_engine`

## Requirements
- R1: Reset sets every channel register to zero and drives `bus_req` and `irq` low. A write on `cfg_wr` stores `cfg_wdata` into the register that `cfg_sel` = {channel, index} selects. `cfg_rdata` returns that register combinationally, zero-extended: counter 16 bits, control 10 bits.
- R2: Each request line passes through a two-flop synchronizer. A channel starts transfers only while its run bit (bit 0) is 1 and its synchronized request is high. With the request low, no bus cycle starts.
- R3: `bus_io` equals control bit 6 during source reads and control bit 7 during destination writes.
- R4: After each transfer each pointer moves by its own 2-bit step field (bits 3:2 for the source, bits 5:4 for the destination). The codes are 01 increment, 10 decrement, and 00 or 11 hold. The step is 1 in byte mode (bit 1 = 0) and 2 in word mode, modulo 2^20.
- R5: A transfer is all its reads followed by all its writes. A byte uses one read and one write. In word mode, an even address takes one word cycle (`bus_word` = 1). An odd address takes two byte cycles: the low byte at the address, then the high byte at the address plus one. A transfer therefore takes two to four bus cycles.
- R6: While `bus_req` is high and `bus_ack` is low, the address, space, size, direction and write data stay stable.
- R7: The counter decrements once per transfer. With bit 8 set, the transfer that brings the counter to zero clears the run bit. A channel with bit 8 set and a count of zero starts no transfer.
- R8: With bit 8 clear, the counter wraps past zero and the channel keeps transferring.
- R9: With bits 8 and 9 set, `irq[channel]` rises one cycle after the final write is acknowledged. It stays high until that channel's control word is written.
- R10: When both channels are eligible, channel 0 goes first. The engine switches channels only between complete transfers.
- R11: Reset abandons a transfer in progress. After reset, both channels are stopped and no bus cycle starts even if the request lines are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| drq | input | 2 | Asynchronous per-channel transfer requests, level sensitive |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | {channel, register index} |
| cfg_wdata | input | 20 | Register write data |
| cfg_rdata | output | 20 | Selected register, zero-extended |
| bus_req | output | 1 | Bus cycle request (valid) |
| bus_ack | input | 1 | Bus cycle completion (ready) |
| bus_addr | output | 20 | Bus cycle address |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_word | output | 1 | 1 = word cycle, 0 = byte cycle |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken while bus_ack is high |
| irq | output | 2 | Per-channel terminal-count interrupt |

## Verification
The mover is exercised with several pointer setups:
- Byte copies from memory to I/O.
- Word copies with an odd source and with an odd destination. These show whether the split into byte cycles, and the order in which the halves are reassembled, are right.
- Decrementing and holding pointers. These show that the step is chosen per side and per size.

The counter is tested with an unbounded count, a zero count with stop enabled, and a terminal count with interrupt. Two cases separate fixed priority from a mid-transfer switch: both channels raised at once, and channel 0 raised during a split transfer of channel 1. Acknowledge delays and a reset in the middle of a cycle cover back-pressure and abandonment.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  // control word bit positions
  localparam int C_RUN    = 0;
  localparam int C_WORD   = 1;
  localparam int C_SSTEP  = 2;
  localparam int C_DSTEP  = 4;
  localparam int C_SIO    = 6;
  localparam int C_DIO    = 7;
  localparam int C_TCSTOP = 8;
  localparam int C_IRQEN  = 9;
  localparam int CTRL_W   = 10;

  // register indices within a channel
  localparam logic [1:0] REG_SRC = 2'd0;
  localparam logic [1:0] REG_DST = 2'd1;
  localparam logic [1:0] REG_CNT = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;

  // pointer step codes
  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_WR0, S_WR1, S_DONE
  } seq_state_t;
endpackage

// File: rtl/dma2_sync.sv
module dma2_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dma2_chan.sv
module dma2_chan import dma2_pkg::*; #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        idx,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              req_sync,
  input  logic              xfer_done,
  output logic              elig,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              word,
  output logic              src_io,
  output logic              dst_io,
  output logic              irq
);
  logic [CNT_W-1:0]  count;
  logic [CTRL_W-1:0] ctrl;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p,
                                                input logic [1:0] mode,
                                                input logic wsz);
    logic [ADDR_W-1:0] d;
    d = wsz ? ADDR_W'(2) : ADDR_W'(1);
    case (mode)
      STEP_INC: return p + d;
      STEP_DEC: return p - d;
      default:  return p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
      count   <= '0;
      ctrl    <= '0;
      irq     <= 1'b0;
    end else begin
      if (xfer_done) begin
        src_ptr <= advance(src_ptr, ctrl[C_SSTEP +: 2], ctrl[C_WORD]);
        dst_ptr <= advance(dst_ptr, ctrl[C_DSTEP +: 2], ctrl[C_WORD]);
        count   <= count - CNT_W'(1);
        if (ctrl[C_TCSTOP] && count == CNT_W'(1)) begin
          ctrl[C_RUN] <= 1'b0;
          if (ctrl[C_IRQEN]) irq <= 1'b1;
        end
      end
      // a register write in the same cycle takes precedence
      if (wr_en) begin
        case (idx)
          REG_SRC: src_ptr <= wr_data;
          REG_DST: dst_ptr <= wr_data;
          REG_CNT: count   <= wr_data[CNT_W-1:0];
          default: begin
            ctrl <= wr_data[CTRL_W-1:0];
            irq  <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      REG_SRC: rd_data = src_ptr;
      REG_DST: rd_data = dst_ptr;
      REG_CNT: rd_data = ADDR_W'(count);
      default: rd_data = ADDR_W'(ctrl);
    endcase
  end

  assign elig   = ctrl[C_RUN] && req_sync && !(ctrl[C_TCSTOP] && count == '0);
  assign word   = ctrl[C_WORD];
  assign src_io = ctrl[C_SIO];
  assign dst_io = ctrl[C_DIO];
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq import dma2_pkg::*; #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0]              elig,
  input  logic [NCH-1:0][ADDR_W-1:0]  src_ptr,
  input  logic [NCH-1:0][ADDR_W-1:0]  dst_ptr,
  input  logic [NCH-1:0]              word,
  input  logic [NCH-1:0]              src_io,
  input  logic [NCH-1:0]              dst_io,
  output logic [NCH-1:0]              done_vec,
  output logic                        bus_req,
  input  logic                        bus_ack,
  output logic [ADDR_W-1:0]           bus_addr,
  output logic                        bus_io,
  output logic                        bus_word,
  output logic                        bus_wr,
  output logic [DATA_W-1:0]           bus_wdata,
  input  logic [DATA_W-1:0]           bus_rdata
);
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BYTE_W = DATA_W / 2;

  seq_state_t        state;
  logic [CH_W-1:0]   cur, pick;
  logic [ADDR_W-1:0] a_src, a_dst;
  logic              x_word, x_sio, x_dio;
  logic [DATA_W-1:0] hold;

  // lowest channel index wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) if (elig[i]) pick = CH_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      a_src  <= '0;
      a_dst  <= '0;
      x_word <= 1'b0;
      x_sio  <= 1'b0;
      x_dio  <= 1'b0;
      hold   <= '0;
    end else begin
      case (state)
        S_IDLE: if (|elig) begin
          cur    <= pick;
          a_src  <= src_ptr[pick];
          a_dst  <= dst_ptr[pick];
          x_word <= word[pick];
          x_sio  <= src_io[pick];
          x_dio  <= dst_io[pick];
          state  <= S_RD0;
        end
        S_RD0: if (bus_ack) begin
          if (!x_word) begin
            hold  <= {{BYTE_W{1'b0}}, bus_rdata[BYTE_W-1:0]};
            state <= S_WR0;
          end else if (a_src[0]) begin
            hold[BYTE_W-1:0] <= bus_rdata[BYTE_W-1:0];
            state <= S_RD1;
          end else begin
            hold  <= bus_rdata;
            state <= S_WR0;
          end
        end
        S_RD1: if (bus_ack) begin
          hold[DATA_W-1:BYTE_W] <= bus_rdata[BYTE_W-1:0];
          state <= S_WR0;
        end
        S_WR0: if (bus_ack) state <= (x_word && a_dst[0]) ? S_WR1 : S_DONE;
        S_WR1: if (bus_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_wr    = 1'b0;
    bus_io    = x_sio;
    bus_word  = 1'b0;
    bus_addr  = a_src;
    bus_wdata = '0;
    case (state)
      S_RD0: begin
        bus_req  = 1'b1;
        bus_word = x_word && !a_src[0];
      end
      S_RD1: begin
        bus_req  = 1'b1;
        bus_addr = a_src + ADDR_W'(1);
      end
      S_WR0: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_io    = x_dio;
        bus_addr  = a_dst;
        bus_word  = x_word && !a_dst[0];
        bus_wdata = (x_word && !a_dst[0]) ? hold
                                          : {{BYTE_W{1'b0}}, hold[BYTE_W-1:0]};
      end
      S_WR1: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_io    = x_dio;
        bus_addr  = a_dst + ADDR_W'(1);
        bus_wdata = {{BYTE_W{1'b0}}, hold[DATA_W-1:BYTE_W]};
      end
      default: ;
    endcase
  end

  always_comb begin
    done_vec = '0;
    if (state == S_DONE) done_vec[cur] = 1'b1;
  end
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine import dma2_pkg::*; #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        drq,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_io,
  output logic              bus_word,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        irq
);
  localparam int NCH   = 2;
  localparam int SEL_W = 3;

  logic [NCH-1:0]             req_sync, elig, done_vec, word, src_io, dst_io;
  logic [NCH-1:0][ADDR_W-1:0] src_ptr, dst_ptr, rd_vec;

  dma2_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(drq), .q(req_sync)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr && (cfg_sel[SEL_W-1] == ch[0])),
      .idx      (cfg_sel[1:0]),
      .wr_data  (cfg_wdata),
      .rd_data  (rd_vec[ch]),
      .req_sync (req_sync[ch]),
      .xfer_done(done_vec[ch]),
      .elig     (elig[ch]),
      .src_ptr  (src_ptr[ch]),
      .dst_ptr  (dst_ptr[ch]),
      .word     (word[ch]),
      .src_io   (src_io[ch]),
      .dst_io   (dst_io[ch]),
      .irq      (irq[ch])
    );
  end

  assign cfg_rdata = rd_vec[cfg_sel[SEL_W-1]];

  dma2_seq #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .elig(elig), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .word(word), .src_io(src_io), .dst_io(dst_io), .done_vec(done_vec),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_io(bus_io),
    .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/dma2_engine_chk.sv
module dma2_engine_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NCH    = 2,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_io,
  input logic              bus_word,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cfg_wr,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    done_vec
);
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_io) &&
      $stable(bus_word) && $stable(bus_wr) && $stable(bus_wdata));

  a_r5_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_word |-> !bus_addr[0]);

  a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    |done_vec |-> $past(bus_req && bus_ack && bus_wr));

  for (genvar k = 0; k < NCH; k++) begin : g_irq
    a_r9_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[k]) |-> $past(bus_req && bus_ack && bus_wr, 2));

    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && cfg_sel == SEL_W'(k * 4 + 3) |=> !irq[k]);
  end
endmodule

bind dma2_engine dma2_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_addr(bus_addr), .bus_io(bus_io), .bus_word(bus_word), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .irq(irq),
  .done_vec(done_vec)
);

// File: tb/dma2_engine_bench.sv
module dma2_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  drq = 2'b00;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_rdata;
  logic        bus_req, bus_io, bus_word, bus_wr;
  logic        bus_ack = 1'b0;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic [1:0]  irq;

  dma2_engine u_dma2_engine (
    .clk(clk), .rst_n(rst_n), .drq(drq), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_io(bus_io), .bus_word(bus_word), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  mem_sp [0:4095];
  logic [7:0]  io_sp  [0:4095];
  logic [19:0] wlog [0:63];
  logic        wlog_io [0:63];
  logic        wlog_word [0:63];
  logic [19:0] rlog [0:63];
  logic        rlog_io [0:63];
  logic        rlog_word [0:63];
  int rd_n = 0, wr_n = 0, ack_delay = 0, wait_n = 0;
  int n_chk = 0, n_bad = 0;

  // target model: acknowledges after ack_delay waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      wait_n  = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wait_n < ack_delay) wait_n++;
      else begin
        logic [11:0] a;
        wait_n = 0;
        a = bus_addr[11:0];
        if (bus_wr) begin
          if (bus_io) begin
            io_sp[a] = bus_wdata[7:0];
            if (bus_word) io_sp[a+12'd1] = bus_wdata[15:8];
          end else begin
            mem_sp[a] = bus_wdata[7:0];
            if (bus_word) mem_sp[a+12'd1] = bus_wdata[15:8];
          end
          if (wr_n < 64) begin
            wlog[wr_n] = bus_addr; wlog_io[wr_n] = bus_io; wlog_word[wr_n] = bus_word;
          end
          wr_n++;
        end else begin
          if (bus_io) bus_rdata = bus_word ? {io_sp[a+12'd1], io_sp[a]} : {8'h00, io_sp[a]};
          else        bus_rdata = bus_word ? {mem_sp[a+12'd1], mem_sp[a]} : {8'h00, mem_sp[a]};
          if (rd_n < 64) begin
            rlog[rd_n] = bus_addr; rlog_io[rd_n] = bus_io; rlog_word[rd_n] = bus_word;
          end
          rd_n++;
        end
        bus_ack = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] ctl(bit run, bit wsz, logic [1:0] ss, logic [1:0] ds,
                                      bit sio, bit dio, bit tcs, bit ie);
    return {10'd0, ie, tcs, dio, sio, ds, ss, wsz, run};
  endfunction

  task automatic cfg_write(input int sel, input logic [19:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int sel, output logic [19:0] d);
    @(negedge clk);
    cfg_sel = 3'(sel);
    #1 d = cfg_rdata;
  endtask

  task automatic setup(input int ch, input logic [19:0] s, input logic [19:0] d,
                       input logic [19:0] cnt, input logic [19:0] c);
    cfg_write(ch * 4 + 0, s);
    cfg_write(ch * 4 + 1, d);
    cfg_write(ch * 4 + 2, cnt);
    cfg_write(ch * 4 + 3, c);
  endtask

  task automatic wait_stop(input int ch);
    logic [19:0] v;
    for (int g = 0; g < 3000; g++) begin
      cfg_read(ch * 4 + 3, v);
      if (!v[0]) break;
    end
  endtask

  task automatic clr_log();
    rd_n = 0; wr_n = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; drq = 2'b00; cfg_wr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_regs();
    logic [19:0] v;
    for (int s = 0; s < 8; s++) begin
      cfg_read(s, v);
      chk($sformatf("R1 reset reg %0d", s), v, 0);
    end
    chk("R1 reset bus_req", bus_req, 0);
    chk("R1 reset irq", irq, 0);
    cfg_write(4, 20'h12345);
    cfg_read(4, v);
    chk("R1 src readback", v, 20'h12345);
    cfg_write(2, 20'hABCDE);
    cfg_read(2, v);
    chk("R1 count 16-bit readback", v, 20'h0BCDE);
    cfg_write(4, 0);
    cfg_write(2, 0);
  endtask

  task automatic t_byte_copy();
    logic [19:0] v;
    clr_log();
    setup(0, 20'h100, 20'h200, 4, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 0));
    drq = 2'b01;
    wait_stop(0);
    drq = 2'b00;
    for (int i = 0; i < 4; i++)
      chk("R5 byte data", io_sp[12'h200 + 12'(i)], mem_sp[12'h100 + 12'(i)]);
    cfg_read(0, v); chk("R4 src inc", v, 20'h104);
    cfg_read(1, v); chk("R4 dst inc", v, 20'h204);
    cfg_read(2, v); chk("R7 count zero", v, 0);
    chk("R5 read count", rd_n, 4);
    chk("R5 write count", wr_n, 4);
    chk("R3 src space mem", rlog_io[0], 0);
    chk("R3 dst space io", wlog_io[0], 1);
  endtask

  task automatic t_word_split();
    logic [19:0] v;
    clr_log();
    setup(0, 20'h301, 20'h400, 2, ctl(1, 1, 2'b01, 2'b01, 0, 0, 1, 0));
    drq = 2'b01;
    wait_stop(0);
    drq = 2'b00;
    chk("R5 odd src reads", rd_n, 4);
    chk("R5 even dst writes", wr_n, 2);
    chk("R5 first read low byte", {rlog_word[0], rlog[0]}, {1'b0, 20'h301});
    chk("R5 second read high byte", {rlog_word[1], rlog[1]}, {1'b0, 20'h302});
    chk("R5 aligned word write", {wlog_word[0], wlog[0]}, {1'b1, 20'h400});
    for (int i = 0; i < 4; i++)
      chk("R5 odd src data", mem_sp[12'h400 + 12'(i)], mem_sp[12'h301 + 12'(i)]);
    cfg_read(0, v); chk("R4 word src step", v, 20'h305);
    // odd destination, with back-pressure
    clr_log();
    ack_delay = 2;
    setup(0, 20'h500, 20'h601, 2, ctl(1, 1, 2'b01, 2'b01, 0, 1, 1, 0));
    drq = 2'b01;
    wait_stop(0);
    drq = 2'b00;
    ack_delay = 0;
    chk("R6 even src reads", rd_n, 2);
    chk("R6 odd dst writes", wr_n, 4);
    chk("R5 split write order", {wlog[0], wlog[1]}, {20'h601, 20'h602});
    for (int i = 0; i < 4; i++)
      chk("R6 odd dst data", io_sp[12'h601 + 12'(i)], mem_sp[12'h500 + 12'(i)]);
  endtask

  task automatic t_dec_hold();
    logic [19:0] v;
    clr_log();
    setup(0, 20'h703, 20'h010, 3, ctl(1, 0, 2'b10, 2'b00, 0, 1, 1, 0));
    drq = 2'b01;
    wait_stop(0);
    drq = 2'b00;
    chk("R4 hold dst last byte", io_sp[12'h010], mem_sp[12'h701]);
    cfg_read(0, v); chk("R4 src dec byte", v, 20'h700);
    cfg_read(1, v); chk("R4 dst hold", v, 20'h010);
    setup(0, 20'h720, 20'h7A0, 2, ctl(1, 1, 2'b10, 2'b01, 0, 0, 1, 0));
    drq = 2'b01;
    wait_stop(0);
    drq = 2'b00;
    cfg_read(0, v); chk("R4 src dec word", v, 20'h71C);
    cfg_read(1, v); chk("R4 dst inc word", v, 20'h7A4);
    chk("R4 dec word data0", mem_sp[12'h7A1], mem_sp[12'h721]);
    chk("R4 dec word data1", mem_sp[12'h7A2], mem_sp[12'h71E]);
  endtask

  task automatic t_zero_count();
    logic [19:0] v;
    clr_log();
    setup(0, 20'h100, 20'h200, 0, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 0));
    drq = 2'b01;
    repeat (30) @(negedge clk);
    chk("R7 zero count no reads", rd_n, 0);
    cfg_read(3, v); chk("R7 zero count run kept", v[0], 1);
    drq = 2'b00;
    cfg_write(3, 0);
    repeat (20) @(negedge clk);
    drq = 2'b01;
    repeat (20) @(negedge clk);
    chk("R2 run clear no cycles", rd_n, 0);
    drq = 2'b00;
  endtask

  task automatic t_unbounded();
    logic [19:0] v;
    int n;
    clr_log();
    setup(1, 20'h000, 20'h300, 2, ctl(1, 0, 2'b01, 2'b01, 0, 1, 0, 0));
    drq = 2'b10;
    for (int g = 0; g < 500 && wr_n < 5; g++) @(negedge clk);
    drq = 2'b00;
    repeat (20) @(negedge clk);
    n = wr_n;
    chk("R8 passed zero", n > 2, 1);
    cfg_read(6, v); chk("R8 count wraps", v, 20'((2 - n) & 16'hFFFF));
    cfg_read(7, v); chk("R8 still running", v[0], 1);
    cfg_read(5, v); chk("R8 dst steps", v, 20'h300 + 20'(n));
    repeat (20) @(negedge clk);
    chk("R2 request low idles", wr_n, n);
    cfg_write(7, 0);
  endtask

  task automatic t_irq();
    setup(1, 20'h020, 20'h320, 1, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 1));
    drq = 2'b10;
    wait_stop(1);
    drq = 2'b00;
    chk("R9 irq raised", irq, 2'b10);
    cfg_write(7, 0);
    @(negedge clk);
    chk("R9 irq cleared", irq, 2'b00);
  endtask

  task automatic t_priority();
    clr_log();
    setup(1, 20'h040, 20'h900, 2, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 0));
    setup(0, 20'h050, 20'h800, 2, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 0));
    drq = 2'b11;
    wait_stop(0);
    wait_stop(1);
    drq = 2'b00;
    chk("R10 ch0 first", {wlog[0], wlog[1]}, {20'h800, 20'h801});
    chk("R10 ch1 after", {wlog[2], wlog[3]}, {20'h900, 20'h901});
    // channel 0 raised during a split transfer of channel 1
    clr_log();
    ack_delay = 3;
    setup(1, 20'h061, 20'hA01, 1, ctl(1, 1, 2'b01, 2'b01, 0, 1, 1, 0));
    setup(0, 20'h070, 20'hB00, 1, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 0));
    drq = 2'b10;
    for (int g = 0; g < 500 && rd_n < 1; g++) @(negedge clk);
    drq = 2'b11;
    wait_stop(1);
    wait_stop(0);
    drq = 2'b00;
    ack_delay = 0;
    chk("R10 no mid switch", {wlog[0], wlog[1], wlog[2]}, {20'hA01, 20'hA02, 20'hB00});
  endtask

  task automatic t_reset_abort();
    logic [19:0] v;
    clr_log();
    ack_delay = 50;
    setup(0, 20'h100, 20'h200, 5, ctl(1, 0, 2'b01, 2'b01, 0, 1, 1, 0));
    drq = 2'b01;
    for (int g = 0; g < 100 && !bus_req; g++) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ack_delay = 0;
    clr_log();
    @(negedge clk);
    chk("R11 req dropped", bus_req, 0);
    cfg_read(3, v); chk("R11 channel stopped", v, 0);
    repeat (20) @(negedge clk);
    chk("R11 no cycles after reset", rd_n, 0);
    drq = 2'b00;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem_sp[i] = 8'((i * 7 + 3) & 255);
      io_sp[i]  = 8'h00;
    end
    do_reset();
    t_reset_regs();
    t_byte_copy();
    t_word_split();
    t_dec_hold();
    t_zero_count();
    t_unbounded();
    t_irq();
    t_priority();
    t_reset_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule